// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface and walks the memory device from power-on to the point where it takes ordinary traffic. After reset it keeps the clock-enable pin low for a configurable settling interval. It then raises clock-enable with a NOP and issues a fixed series of commands. The series is: precharge of all banks, an extended mode write that enables the DLL, a mode write that resets the DLL, a second precharge of all banks, a configurable number of auto-refresh commands, and a closing mode write that sets the operating burst and latency fields.

Every gap between commands is a parameter counted in controller clock cycles, and the bus drives NOP inside each gap. A separate counter tracks the DLL lock interval. It starts at the command that last reset the DLL and runs alongside the rest of the series. The ready flag rises only when both the closing mode write's gap and the lock interval have elapsed. A build option drops the separate DLL-reset step. The enable command resets the DLL on its own, so in that build the lock interval is counted from the enable command.

Top module: `ddr_init_seq`

## Requirements
- R1: From reset release the command bus carries NOP ({cs_n,ras_n,cas_n,we_n} = 0111) and clock-enable stays low for T_STAB clock cycles. Clock-enable goes high, still with NOP, at cycle T_STAB after release.
- R2: The first command is precharge-all (pins 0010, address bit 10 high, all other address and bank bits low), one cycle after clock-enable rises.
- R3: T_RP cycles after that precharge, an extended mode write enabling the DLL is issued: pins 0000, bank = 01, address all zero.
- R4: With the DLL-reset step present, a mode write follows T_MRD cycles later. It has pins 0000, bank = 00, address bit 8 high, and the operating mode fields in the low address bits.
- R5: A second precharge-all follows the previous mode command by T_MRD cycles.
- R6: N_REF auto-refresh commands (pins 0001, address and bank zero) follow. The first comes T_RP after the second precharge, and each later one comes T_RFC after the one before.
- R7: T_RFC after the last refresh, a mode write is issued with bank 00 and address bit 8 low. Burst-length code is in address bits 2:0, the interleave bit is address bit 3, the CAS code is in bits 6:4, and all other bits are zero.
- R8: init_done rises at the later of two cycles: the closing mode write plus T_MRD, and the DLL-reset command plus T_DLL.
- R9: In the build without the DLL-reset step, no mode write with bit 8 high appears. The second precharge follows the enable command by T_MRD, and the lock interval is counted from the enable command.
- R10: Between commands, and at all times after init_done, the bus carries NOP. Once high, init_done and clock-enable stay high until reset.
- R11: Reset asserted at any point returns clock-enable low, init_done low and the bus to NOP at once. After release the whole series starts again from the settling interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| mem_cke | output | 1 | Clock enable to the device |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W | Bank address |
| mem_addr | output | ADDR_W | Address bus carrying the mode words and the all-banks bit |
| init_done | output | 1 | Device ready for any command |

## Verification
Two builds run side by side from the same reset.

The first keeps the DLL-reset step, uses three refreshes and a short lock interval, so the closing mode write's gap sets when init_done rises. The second drops the DLL-reset step, uses two refreshes and a long lock interval, so the lock counter sets the ready cycle. Together they separate the two limits on init_done and show that the lock is counted from the right command in each build.

A reset pulse in the middle of the refresh run checks that the series restarts cleanly. The second complete run then shows that no count or flag carries over from the aborted one.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_PRE_ALL,
    CMD_REFRESH,
    CMD_EXT_DLL_ON,
    CMD_MODE_DLL_RST,
    CMD_MODE_RUN
  } init_cmd_e;

  typedef enum logic [3:0] {
    ST_SETTLE,
    ST_CKE_UP,
    ST_GAP_PRE1,
    ST_GAP_EXT,
    ST_GAP_DLLRST,
    ST_GAP_PRE2,
    ST_GAP_REF,
    ST_GAP_RUN,
    ST_READY
  } init_state_e;

  localparam logic [3:0] PINS_NOP     = 4'b0111;
  localparam logic [3:0] PINS_PRE     = 4'b0010;
  localparam logic [3:0] PINS_REFRESH = 4'b0001;
  localparam logic [3:0] PINS_MODE    = 4'b0000;

  localparam int ALL_BANKS_BIT = 10;
  localparam int DLL_RST_BIT   = 8;

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] reset_val,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load | ~zero;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= reset_val;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R10: an idle timer parks at zero instead of wrapping
  p_timer_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);

endmodule

// File: rtl/ddr_init_lock.sv
module ddr_init_lock #(
  parameter int T_DLL = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic lock_ok
);

  localparam int LOCK_W = (T_DLL < 2) ? 1 : $clog2(T_DLL + 1);

  logic [LOCK_W-1:0] lcnt_q;
  logic              armed_q;
  logic              lcnt_en;

  assign lcnt_en = start | (lcnt_q != '0);
  assign lock_ok = armed_q & (lcnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcnt_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      if (lcnt_en) lcnt_q <= start ? LOCK_W'(T_DLL - 1) : lcnt_q - 1'b1;
      if (start)   armed_q <= 1'b1;
    end
  end

  // R8: once lock is reached it holds until a new DLL reset
  p_lock_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_ok && !start) |=> lock_ok);

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W           = 12,
  parameter int BA_W             = 2,
  parameter int BURST_CODE       = 3,
  parameter int BURST_INTERLEAVE = 0,
  parameter int CAS_CODE         = 2
) (
  input  init_cmd_e          cmd,
  output logic               cs_n,
  output logic               ras_n,
  output logic               cas_n,
  output logic               we_n,
  output logic [BA_W-1:0]    ba,
  output logic [ADDR_W-1:0]  addr
);

  localparam logic [ADDR_W-1:0] RUN_WORD =
      ADDR_W'(BURST_CODE & 7) |
      (ADDR_W'(BURST_INTERLEAVE & 1) << 3) |
      (ADDR_W'(CAS_CODE & 7) << 4);
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << ALL_BANKS_BIT;
  localparam logic [ADDR_W-1:0] DLL_RST   = ADDR_W'(1) << DLL_RST_BIT;

  logic [3:0] pins;

  assign {cs_n, ras_n, cas_n, we_n} = pins;

  always_comb begin
    pins = PINS_NOP;
    ba   = '0;
    addr = '0;
    case (cmd)
      CMD_PRE_ALL: begin
        pins = PINS_PRE;
        addr = ALL_BANKS;
      end
      CMD_REFRESH: pins = PINS_REFRESH;
      CMD_EXT_DLL_ON: begin
        pins = PINS_MODE;
        ba   = BA_W'(1);
      end
      CMD_MODE_DLL_RST: begin
        pins = PINS_MODE;
        addr = RUN_WORD | DLL_RST;
      end
      CMD_MODE_RUN: begin
        pins = PINS_MODE;
        addr = RUN_WORD;
      end
      default: pins = PINS_NOP;
    endcase
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W           = 12,
  parameter int BA_W             = 2,
  parameter int T_STAB           = 50000,
  parameter int T_RP             = 3,
  parameter int T_MRD            = 2,
  parameter int T_RFC            = 18,
  parameter int T_DLL            = 200,
  parameter int N_REF            = 2,
  parameter int SKIP_DLL_RST     = 0,
  parameter int BURST_CODE       = 3,
  parameter int BURST_INTERLEAVE = 0,
  parameter int CAS_CODE         = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_cke,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [BA_W-1:0]   mem_ba,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              init_done
);

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_GAP = max_of(max_of(T_STAB, T_RP), max_of(T_MRD, T_RFC));
  localparam int CNT_W   = $clog2(MAX_GAP + 1);
  localparam int REF_W   = $clog2(N_REF + 1);

  localparam logic [CNT_W-1:0] LD_STAB = CNT_W'(T_STAB - 1);
  localparam logic [CNT_W-1:0] LD_RP   = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] LD_MRD  = CNT_W'(T_MRD - 1);
  localparam logic [CNT_W-1:0] LD_RFC  = CNT_W'(T_RFC - 1);
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(N_REF);

  init_state_e      state_q, state_d;
  init_cmd_e        cmd_q, cmd_d;
  logic             cke_q, cke_d;
  logic             done_q, done_d;
  logic [REF_W-1:0] ref_q, ref_d;
  logic             gap_load;
  logic [CNT_W-1:0] gap_val;
  logic             gap_zero;
  logic             lock_start;
  logic             lock_ok;

  // variant chosen by the build: what follows the DLL enable command
  init_cmd_e        after_ext_cmd;
  init_state_e      after_ext_state;
  logic [CNT_W-1:0] after_ext_gap;
  logic             lock_at_ext;

  generate
    if (SKIP_DLL_RST != 0) begin : g_no_dll_rst
      assign after_ext_cmd   = CMD_PRE_ALL;
      assign after_ext_state = ST_GAP_PRE2;
      assign after_ext_gap   = LD_RP;
      assign lock_at_ext     = 1'b1;
    end else begin : g_dll_rst
      assign after_ext_cmd   = CMD_MODE_DLL_RST;
      assign after_ext_state = ST_GAP_DLLRST;
      assign after_ext_gap   = LD_MRD;
      assign lock_at_ext     = 1'b0;
    end
  endgenerate

  ddr_init_timer #(.CNT_W(CNT_W)) u_gap (
    .clk       (clk),
    .rst_n     (rst_n),
    .reset_val (LD_STAB),
    .load      (gap_load),
    .load_val  (gap_val),
    .zero      (gap_zero)
  );

  ddr_init_lock #(.T_DLL(T_DLL)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (lock_start),
    .lock_ok (lock_ok)
  );

  ddr_init_cmd_enc #(
    .ADDR_W           (ADDR_W),
    .BA_W             (BA_W),
    .BURST_CODE       (BURST_CODE),
    .BURST_INTERLEAVE (BURST_INTERLEAVE),
    .CAS_CODE         (CAS_CODE)
  ) u_enc (
    .cmd   (cmd_q),
    .cs_n  (mem_cs_n),
    .ras_n (mem_ras_n),
    .cas_n (mem_cas_n),
    .we_n  (mem_we_n),
    .ba    (mem_ba),
    .addr  (mem_addr)
  );

  always_comb begin
    state_d    = state_q;
    cmd_d      = CMD_NOP;
    cke_d      = cke_q;
    done_d     = done_q;
    ref_d      = ref_q;
    gap_load   = 1'b0;
    gap_val    = '0;
    lock_start = 1'b0;
    if (gap_zero) begin
      case (state_q)
        ST_SETTLE: begin
          cke_d    = 1'b1;
          gap_load = 1'b1;
          gap_val  = '0;
          state_d  = ST_CKE_UP;
        end
        ST_CKE_UP: begin
          cmd_d    = CMD_PRE_ALL;
          gap_load = 1'b1;
          gap_val  = LD_RP;
          state_d  = ST_GAP_PRE1;
        end
        ST_GAP_PRE1: begin
          cmd_d      = CMD_EXT_DLL_ON;
          gap_load   = 1'b1;
          gap_val    = LD_MRD;
          lock_start = lock_at_ext;
          state_d    = ST_GAP_EXT;
        end
        ST_GAP_EXT: begin
          cmd_d      = after_ext_cmd;
          gap_load   = 1'b1;
          gap_val    = after_ext_gap;
          lock_start = ~lock_at_ext;
          state_d    = after_ext_state;
        end
        ST_GAP_DLLRST: begin
          cmd_d    = CMD_PRE_ALL;
          gap_load = 1'b1;
          gap_val  = LD_RP;
          state_d  = ST_GAP_PRE2;
        end
        ST_GAP_PRE2: begin
          cmd_d    = CMD_REFRESH;
          gap_load = 1'b1;
          gap_val  = LD_RFC;
          ref_d    = REF_W'(1);
          state_d  = ST_GAP_REF;
        end
        ST_GAP_REF: begin
          gap_load = 1'b1;
          if (ref_q < REF_LAST) begin
            cmd_d   = CMD_REFRESH;
            gap_val = LD_RFC;
            ref_d   = ref_q + 1'b1;
          end else begin
            cmd_d   = CMD_MODE_RUN;
            gap_val = LD_MRD;
            state_d = ST_GAP_RUN;
          end
        end
        ST_GAP_RUN: begin
          if (lock_ok) begin
            done_d  = 1'b1;
            state_d = ST_READY;
          end
        end
        default: state_d = ST_READY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SETTLE;
      cmd_q   <= CMD_NOP;
      cke_q   <= 1'b0;
      done_q  <= 1'b0;
      ref_q   <= '0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      cke_q   <= cke_d;
      done_q  <= done_d;
      ref_q   <= ref_d;
    end
  end

  assign mem_cke   = cke_q;
  assign init_done = done_q;

  // R1: nothing but NOP reaches the bus while clock-enable is low
  p_nop_cke_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cke |-> ({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == PINS_NOP));

  // R11: clock-enable never drops again without a reset
  p_cke_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cke |=> mem_cke);

  // R10: ready is sticky and the bus stays idle afterwards
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> ({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == PINS_NOP && mem_cke));

  // R8: ready only after the lock counter has reported lock
  p_done_after_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(lock_ok));

  // R6: refresh counter never passes the configured count
  p_ref_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_q <= REF_LAST);

endmodule

// File: tb/test_ddr_init_seq.sv
`timescale 1ns/1ps
module test_ddr_init_seq;

  localparam int T_STAB = 40;
  localparam int T_RP   = 3;
  localparam int T_MRD  = 2;
  localparam int T_RFC  = 7;
  localparam int A_DLL  = 20;
  localparam int A_NREF = 3;
  localparam int B_DLL  = 60;
  localparam int B_NREF = 2;
  localparam int BL     = 3;
  localparam int BT     = 1;
  localparam int CL     = 2;
  localparam logic [11:0] RUN_WORD = 12'(BL) | (12'(BT) << 3) | (12'(CL) << 4);

  typedef struct {
    int         cyc;
    logic [3:0] pins;
    logic [1:0] ba;
    logic [11:0] addr;
    int         kind;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic a_cke, a_cs_n, a_ras_n, a_cas_n, a_we_n, a_done;
  logic [1:0] a_ba;
  logic [11:0] a_addr;
  logic b_cke, b_cs_n, b_ras_n, b_cas_n, b_we_n, b_done;
  logic [1:0] b_ba;
  logic [11:0] b_addr;

  ddr_init_seq #(
    .T_STAB(T_STAB), .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC),
    .T_DLL(A_DLL), .N_REF(A_NREF), .SKIP_DLL_RST(0),
    .BURST_CODE(BL), .BURST_INTERLEAVE(BT), .CAS_CODE(CL)
  ) i_ddr_init_seq (
    .clk(clk), .rst_n(rst_n), .mem_cke(a_cke), .mem_cs_n(a_cs_n),
    .mem_ras_n(a_ras_n), .mem_cas_n(a_cas_n), .mem_we_n(a_we_n),
    .mem_ba(a_ba), .mem_addr(a_addr), .init_done(a_done)
  );

  ddr_init_seq #(
    .T_STAB(T_STAB), .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC),
    .T_DLL(B_DLL), .N_REF(B_NREF), .SKIP_DLL_RST(1),
    .BURST_CODE(BL), .BURST_INTERLEAVE(BT), .CAS_CODE(CL)
  ) i_ddr_init_seq_skip (
    .clk(clk), .rst_n(rst_n), .mem_cke(b_cke), .mem_cs_n(b_cs_n),
    .mem_ras_n(b_ras_n), .mem_cas_n(b_cas_n), .mem_we_n(b_we_n),
    .mem_ba(b_ba), .mem_addr(b_addr), .init_done(b_done)
  );

  exp_t q_a[$];
  exp_t q_b[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   done_a = 0;
  int   done_b = 0;
  int   cyc = 0;
  bit   mon_on = 1'b0;
  bit   finished = 1'b0;

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  function automatic string tag(input int k);
    case (k)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      9: return "R9";
      11: return "R11";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: got %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  task automatic put(input bit which, input int c, input logic [3:0] p,
                     input logic [1:0] ba, input logic [11:0] a, input int k);
    exp_t e;
    e.cyc = c; e.pins = p; e.ba = ba; e.addr = a; e.kind = k;
    if (which) q_b.push_back(e);
    else       q_a.push_back(e);
  endtask

  // driver: builds the expected command list straight from the requirements
  task automatic push_seq(input bit which, input bit skip, input int nref,
                          input int tdll, output int dc);
    int c;
    int ls;
    c = T_STAB + 1;
    put(which, c, 4'b0010, 2'b00, 12'h400, 2);               // R2
    c += T_RP;
    put(which, c, 4'b0000, 2'b01, 12'h000, skip ? 9 : 3);     // R3 / R9
    ls = c;
    if (!skip) begin
      c += T_MRD;
      put(which, c, 4'b0000, 2'b00, RUN_WORD | 12'h100, 4);   // R4
      ls = c;
    end
    c += T_MRD;
    put(which, c, 4'b0010, 2'b00, 12'h400, skip ? 9 : 5);     // R5 / R9
    c += T_RP;
    for (int i = 0; i < nref; i++) begin
      put(which, c, 4'b0001, 2'b00, 12'h000, 6);              // R6
      c += T_RFC;
    end
    put(which, c, 4'b0000, 2'b00, RUN_WORD, 7);               // R7
    dc = (c + T_MRD > ls + tdll) ? c + T_MRD : ls + tdll;     // R8
  endtask

  // monitor: compares each build's outputs with its scoreboard queue
  task automatic observe(input bit which, input logic cke, input logic [3:0] pins,
                         input logic [1:0] ba, input logic [11:0] addr, input logic done);
    exp_t e;
    int   qs;
    int   dc;
    qs = which ? q_b.size() : q_a.size();
    dc = which ? done_b : done_a;
    chk("R1", "clock enable", int'(cke), int'(cyc >= T_STAB));
    chk(which ? "R9" : "R8", "init_done", int'(done), int'(cyc >= dc));
    if (pins != 4'b0111) begin
      if (qs == 0) begin
        chk("R10", "unexpected command", int'(pins), 7);
      end else begin
        if (which) e = q_b.pop_front();
        else       e = q_a.pop_front();
        chk(tag(e.kind), "command cycle", cyc, e.cyc);
        chk(tag(e.kind), "command pins", int'(pins), int'(e.pins));
        chk(tag(e.kind), "bank", int'(ba), int'(e.ba));
        chk(tag(e.kind), "address", int'(addr), int'(e.addr));
      end
    end else if (qs > 0) begin
      e = which ? q_b[0] : q_a[0];
      if (e.cyc == cyc) chk(tag(e.kind), "missing command", int'(pins), int'(e.pins));
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      observe(1'b0, a_cke, {a_cs_n, a_ras_n, a_cas_n, a_we_n}, a_ba, a_addr, a_done);
      observe(1'b1, b_cke, {b_cs_n, b_ras_n, b_cas_n, b_we_n}, b_ba, b_addr, b_done);
    end
  end

  task automatic reset_state(input string req);
    chk(req, "reset cke A", int'(a_cke), 0);
    chk(req, "reset done A", int'(a_done), 0);
    chk(req, "reset bus A", int'({a_cs_n, a_ras_n, a_cas_n, a_we_n}), 7);
    chk(req, "reset cke B", int'(b_cke), 0);
    chk(req, "reset done B", int'(b_done), 0);
    chk(req, "reset bus B", int'({b_cs_n, b_ras_n, b_cas_n, b_we_n}), 7);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog expired: got 0 expected 1");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    reset_state("R1");

    // first run, aborted by reset part way through the refreshes
    push_seq(1'b0, 1'b0, A_NREF, A_DLL, done_a);
    push_seq(1'b1, 1'b1, B_NREF, B_DLL, done_b);
    @(posedge clk);
    #1 rst_n = 1'b1;
    mon_on = 1'b1;
    while (cyc < 55) @(negedge clk);
    @(posedge clk);
    #1 rst_n = 1'b0;
    mon_on = 1'b0;
    #1 reset_state("R11");
    q_a.delete();
    q_b.delete();
    repeat (2) @(posedge clk);
    #1 reset_state("R11");

    // full run after the abort
    push_seq(1'b0, 1'b0, A_NREF, A_DLL, done_a);
    push_seq(1'b1, 1'b1, B_NREF, B_DLL, done_b);
    @(posedge clk);
    #1 rst_n = 1'b1;
    mon_on = 1'b1;
    while (cyc < done_b + 20) @(negedge clk);
    mon_on = 1'b0;
    chk("R7", "commands left A", q_a.size(), 0);
    chk("R9", "commands left B", q_b.size(), 0);
    chk("R10", "done held A", int'(a_done), 1);
    chk("R10", "done held B", int'(b_done), 1);
    summary();
  end

endmodule